// File: doc/BRIEF.md
# Fracturable Look-Up-Table Logic Cell

This block is a model of a single programmable logic cell that can be built in synthesis. It takes eight data inputs and a static configuration, and it gives two combinational results, a carry output and two registered outputs. A two-bit mode field decides how one 64-bit truth-table mask is split up:

- **Normal mode** treats the mask as one six-input look-up table.
- **Extended mode** treats it as two five-input tables. The two tables share four inputs, and a 2:1 multiplexer picks between them, which gives a seven-input function.
- **Arithmetic mode** treats it as four four-input tables. These feed two chained full adders and act as pre-adder logic.

Either output register can load the logic result or a "packed" data input that bypasses the logic. Which inputs can be packed depends on the mode.

The configuration pins (mode, mask, packing bits) are treated as static. The cell has four modes, and each configuration "state" is a fixed mode:

- `MODE_NORMAL`
- `MODE_EXTENDED`
- `MODE_ARITH`
- `MODE_ILLEGAL`

There are no run-time transitions between modes. Each register has only two transitions: it loads its selected source on an enabled clock edge, or it clears on reset.

Top module: `flex_logic_cell`

## Requirements
- R1: Inputs map to `data_in` bits as a=0, b=1, c=2, d=3, e0=4, e1=5, f0=6, f1=7. With `cfg_mode`=00 (normal), `comb0` = `cfg_mask[{f1,e1,d,c,b,a}]`, and `comb1` and `carry_out` are 0.
- R2: With `cfg_mode`=01 (extended), `comb0` = `cfg_mask[32+{e1,d,c,b,a}]` when f0=1, else `cfg_mask[{e0,d,c,b,a}]`. `comb1` and `carry_out` are 0.
- R3: With `cfg_mode`=10 (arithmetic), the four table outputs are:
  - L0 = `cfg_mask[{d,c,b,a}]`
  - L1 = `cfg_mask[16+{d,c,b,a}]`
  - L2 = `cfg_mask[32+{f1,e1,d,c}]`
  - L3 = `cfg_mask[48+{f1,e1,d,c}]`

  Then `comb0` = L0^L1^`carry_in`, and k0 is the majority of L0, L1 and `carry_in`. `comb1` = L2^L3^k0, and `carry_out` is the majority of L2, L3 and k0.
- R4: With `cfg_mode`=11, `comb0`, `comb1` and `carry_out` are 0, and both registers load 0 on an enabled edge.
- R5: When `rst` is high at a rising edge, `q0` and `q1` become 0 whatever the value of `en`.
- R6: When `en` is low (and `rst` is low), `q0` and `q1` keep their values.
- R7: In normal mode, `q0` loads e0 if `cfg_pack0`=1, else `comb0`. `q1` loads the packed input if `cfg_pack1`=1, else `comb1`.
- R8: In normal mode with `cfg_pack1`=1, `q1` packs f1 only when `cfg_pack1_alt`=1 and `cfg_pack0`=1, which means the six-input result is not registered. In every other case it packs f0.
- R9: In extended mode, `q0` loads f1 if `cfg_pack0`=1, else `comb0`. `q1` loads 0 on every enabled edge.
- R10: In arithmetic mode, `q0` loads e0 if `cfg_pack0`=1, else `comb0`. `q1` loads f0 if `cfg_pack1`=1, else `comb1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset of both registers |
| en | input | 1 | Shared register enable |
| cfg_mode | input | 2 | Mode: 00 normal, 01 extended, 10 arithmetic, 11 illegal |
| cfg_mask | input | 64 | Truth-table mask, split according to the mode |
| cfg_pack0 | input | 1 | Register 0 takes its packed input |
| cfg_pack1 | input | 1 | Register 1 takes its packed input |
| cfg_pack1_alt | input | 1 | Normal mode: request f1 as the packed source of register 1 |
| data_in | input | 8 | Data inputs a..f1 (bit map in R1) |
| carry_in | input | 1 | Carry into adder 0 |
| comb0 | output | 1 | Combinational result 0 |
| comb1 | output | 1 | Combinational result 1 |
| carry_out | output | 1 | Carry out of adder 1 |
| q0 | output | 1 | Register 0 output |
| q1 | output | 1 | Register 1 output |

## Verification
The top has no parameters of its own. The bench builds the cell as it is: a 64-bit mask, two adder stages, and sub-tables of six, five and four inputs. All of these are fixed by the cell's own structure, so every table entry and both carry links can be reached from the ports. Random masks, data and carry values cover each mode against an independent reference. Directed steps cover the following:
- the f1 packing rule in both of its branches
- the register-1 lockout in extended mode
- clearing by the illegal code
- hold while the enable is low
- a reset taken with the enable low
- an all-ones mask that forces carry to ripple through both adders

// File: rtl/flc_pkg.sv
package flc_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_EXTENDED = 2'b01,
        MODE_ARITH    = 2'b10,
        MODE_ILLEGAL  = 2'b11
    } cell_mode_e;

    localparam int DATA_W  = 8;
    localparam int MASK_W  = 64;
    localparam int IDX_A   = 0;
    localparam int IDX_B   = 1;
    localparam int IDX_C   = 2;
    localparam int IDX_D   = 3;
    localparam int IDX_E0  = 4;
    localparam int IDX_E1  = 5;
    localparam int IDX_F0  = 6;
    localparam int IDX_F1  = 7;
endpackage

// File: rtl/flc_lut.sv
module flc_lut #(
    parameter int K = 4,
    localparam int ENTRIES = 1 << K
) (
    input  logic [ENTRIES-1:0] mask,
    input  logic [K-1:0]       sel,
    output logic               y
);
    assign y = mask[sel];
endmodule

// File: rtl/flc_arith.sv
module flc_arith #(
    parameter int STAGES = 2
) (
    input  logic [STAGES-1:0] op_x,
    input  logic [STAGES-1:0] op_y,
    input  logic              cin,
    output logic [STAGES-1:0] sum,
    output logic              cout
);
    logic [STAGES:0] chain;

    assign chain[0] = cin;

    for (genvar s = 0; s < STAGES; s++) begin : g_fa
        assign sum[s]     = op_x[s] ^ op_y[s] ^ chain[s];
        assign chain[s+1] = (op_x[s] & op_y[s]) | (chain[s] & (op_x[s] ^ op_y[s]));
    end

    assign cout = chain[STAGES];
endmodule

// File: rtl/flc_regs.sv
module flc_regs (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d0,
    input  logic d1,
    output logic q0,
    output logic q1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q0 <= 1'b0;
            q1 <= 1'b0;
        end else if (en) begin
            q0 <= d0;
            q1 <= d1;
        end
    end
endmodule

// File: rtl/flex_logic_cell.sv
module flex_logic_cell
    import flc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        cfg_mode,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic              cfg_pack0,
    input  logic              cfg_pack1,
    input  logic              cfg_pack1_alt,
    input  logic [DATA_W-1:0] data_in,
    input  logic              carry_in,
    output logic              comb0,
    output logic              comb1,
    output logic              carry_out,
    output logic              q0,
    output logic              q1
);
    localparam int K6       = 6;
    localparam int K5       = K6 - 1;
    localparam int K4       = K6 - 2;
    localparam int N4       = 4;
    localparam int STAGES   = N4 / 2;
    localparam int HALF_W   = MASK_W / 2;
    localparam int QUART_W  = MASK_W / N4;

    cell_mode_e mode;
    assign mode = cell_mode_e'(cfg_mode);

    logic a, b, c, d, e0, e1, f0, f1;
    assign a  = data_in[IDX_A];
    assign b  = data_in[IDX_B];
    assign c  = data_in[IDX_C];
    assign d  = data_in[IDX_D];
    assign e0 = data_in[IDX_E0];
    assign e1 = data_in[IDX_E1];
    assign f0 = data_in[IDX_F0];
    assign f1 = data_in[IDX_F1];

    // Normal mode: one six-input table.
    logic y6;
    flc_lut #(.K(K6)) u_lut6 (
        .mask (cfg_mask),
        .sel  ({f1, e1, d, c, b, a}),
        .y    (y6)
    );

    // Extended mode: two five-input tables sharing a..d, selected by f0.
    logic y5_lo, y5_hi, y7;
    flc_lut #(.K(K5)) u_lut5_lo (
        .mask (cfg_mask[HALF_W-1:0]),
        .sel  ({e0, d, c, b, a}),
        .y    (y5_lo)
    );
    flc_lut #(.K(K5)) u_lut5_hi (
        .mask (cfg_mask[MASK_W-1:HALF_W]),
        .sel  ({e1, d, c, b, a}),
        .y    (y5_hi)
    );
    assign y7 = f0 ? y5_hi : y5_lo;

    // Arithmetic mode: four four-input tables as pre-adder logic.
    logic [N4-1:0] y4;
    for (genvar g = 0; g < N4; g++) begin : g_lut4
        logic [K4-1:0] sel4;
        if (g < N4 / 2) begin : g_low
            assign sel4 = {d, c, b, a};
        end else begin : g_high
            assign sel4 = {f1, e1, d, c};
        end
        flc_lut #(.K(K4)) u_lut4 (
            .mask (cfg_mask[g*QUART_W +: QUART_W]),
            .sel  (sel4),
            .y    (y4[g])
        );
    end

    logic [STAGES-1:0] add_x, add_y, add_sum;
    logic              add_cout;
    for (genvar s = 0; s < STAGES; s++) begin : g_ops
        assign add_x[s] = y4[2*s];
        assign add_y[s] = y4[2*s+1];
    end

    flc_arith #(.STAGES(STAGES)) u_arith (
        .op_x (add_x),
        .op_y (add_y),
        .cin  (carry_in),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Output and register-source selection per mode.
    logic r0_d, r1_d;
    always_comb begin
        comb0     = 1'b0;
        comb1     = 1'b0;
        carry_out = 1'b0;
        r0_d      = 1'b0;
        r1_d      = 1'b0;
        unique case (mode)
            MODE_NORMAL: begin
                comb0 = y6;
                r0_d  = cfg_pack0 ? e0 : y6;
                if (cfg_pack1) begin
                    r1_d = (cfg_pack1_alt && cfg_pack0) ? f1 : f0;
                end
            end
            MODE_EXTENDED: begin
                comb0 = y7;
                r0_d  = cfg_pack0 ? f1 : y7;
            end
            MODE_ARITH: begin
                comb0     = add_sum[0];
                comb1     = add_sum[STAGES-1];
                carry_out = add_cout;
                r0_d      = cfg_pack0 ? e0 : add_sum[0];
                r1_d      = cfg_pack1 ? f0 : add_sum[STAGES-1];
            end
            MODE_ILLEGAL: begin
                comb0 = 1'b0;
            end
        endcase
    end

    flc_regs u_regs (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d0  (r0_d),
        .d1  (r1_d),
        .q0  (q0),
        .q1  (q1)
    );
endmodule

// File: rtl/flc_checker.sv
module flc_checker (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [1:0] cfg_mode,
    input logic       cfg_pack0,
    input logic       cfg_pack1,
    input logic       cfg_pack1_alt,
    input logic [7:0] data_in,
    input logic       comb0,
    input logic       comb1,
    input logic       carry_out,
    input logic       q0,
    input logic       q1
);
    a_r4_illegal_low: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b11) |-> (!comb0 && !comb1 && !carry_out));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(q0) && $stable(q1)));

    a_r8_f1_fallback: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00 && en && cfg_pack1 && cfg_pack1_alt && !cfg_pack0)
        |=> (q1 == $past(data_in[6])));

    a_r9_reg1_locked: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b01 && en) |=> !q1);

    a_r9_pack_f1: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b01 && en && cfg_pack0) |=> (q0 == $past(data_in[7])));

    a_r10_pack_e0: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b10 && en && cfg_pack0) |=> (q0 == $past(data_in[4])));

    a_r10_pack_f0: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b10 && en && cfg_pack1) |=> (q1 == $past(data_in[6])));
endmodule

bind flex_logic_cell flc_checker u_chk (.*);

// File: tb/flex_logic_cell_tb.sv
module flex_logic_cell_tb;
    logic        clk = 1'b0;
    logic        rst, en;
    logic [1:0]  cfg_mode;
    logic [63:0] cfg_mask;
    logic        cfg_pack0, cfg_pack1, cfg_pack1_alt;
    logic [7:0]  data_in;
    logic        carry_in;
    logic        comb0, comb1, carry_out, q0, q1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flex_logic_cell u_dut (
        .clk(clk), .rst(rst), .en(en), .cfg_mode(cfg_mode), .cfg_mask(cfg_mask),
        .cfg_pack0(cfg_pack0), .cfg_pack1(cfg_pack1), .cfg_pack1_alt(cfg_pack1_alt),
        .data_in(data_in), .carry_in(carry_in), .comb0(comb0), .comb1(comb1),
        .carry_out(carry_out), .q0(q0), .q1(q1)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: returns {carry_out, comb1, comb0}
    function automatic logic [2:0] ref_comb(input logic [1:0] m, input logic [63:0] k,
                                            input logic [7:0] x, input logic ci);
        int i0, i1;
        logic l0, l1, l2, l3, s0, s1, k0, k1;
        case (m)
            2'b00: begin
                i0 = x[0] + 2*x[1] + 4*x[2] + 8*x[3] + 16*x[5] + 32*x[7];
                return {2'b00, k[i0]};
            end
            2'b01: begin
                i0 = x[0] + 2*x[1] + 4*x[2] + 8*x[3] + 16*(x[6] ? x[5] : x[4]);
                if (x[6]) i0 = i0 + 32;
                return {2'b00, k[i0]};
            end
            2'b10: begin
                i0 = x[0] + 2*x[1] + 4*x[2] + 8*x[3];
                i1 = x[2] + 2*x[3] + 4*x[5] + 8*x[7];
                l0 = k[i0]; l1 = k[16+i0]; l2 = k[32+i1]; l3 = k[48+i1];
                s0 = l0 ^ l1 ^ ci;
                k0 = (l0 + l1 + ci) >= 2;
                s1 = l2 ^ l3 ^ k0;
                k1 = (l2 + l3 + k0) >= 2;
                return {k1, s1, s0};
            end
            default: return 3'b000;
        endcase
    endfunction

    // Reference: returns {q1, q0} after an enabled edge
    function automatic logic [1:0] ref_regs(input logic [1:0] m, input logic [63:0] k,
                                            input logic [7:0] x, input logic ci,
                                            input logic p0, input logic p1, input logic alt);
        logic [2:0] r;
        r = ref_comb(m, k, x, ci);
        case (m)
            2'b00: return {p1 ? ((alt && p0) ? x[7] : x[6]) : r[1], p0 ? x[4] : r[0]};
            2'b01: return {1'b0, p0 ? x[7] : r[0]};
            2'b10: return {p1 ? x[6] : r[1], p0 ? x[4] : r[0]};
            default: return 2'b00;
        endcase
    endfunction

    task automatic step(input string ctag, input string rtag, input logic [1:0] m,
                        input logic [63:0] k, input logic [7:0] x, input logic ci,
                        input logic p0, input logic p1, input logic alt);
        @(negedge clk);
        cfg_mode = m; cfg_mask = k; data_in = x; carry_in = ci;
        cfg_pack0 = p0; cfg_pack1 = p1; cfg_pack1_alt = alt; en = 1'b1;
        #1 chk(ctag, {5'd0, carry_out, comb1, comb0}, {5'd0, ref_comb(m, k, x, ci)});
        @(posedge clk);
        @(negedge clk);
        chk(rtag, {6'd0, q1, q0}, {6'd0, ref_regs(m, k, x, ci, p0, p1, alt)});
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; cfg_mode = 2'b00; cfg_pack0 = 1'b1; cfg_pack1 = 1'b1;
        data_in = 8'hFF;
        @(posedge clk); @(negedge clk);
        chk("R5 reset state", {6'd0, q1, q0}, 8'd0);
        rst = 1'b0;
    endtask

    task automatic t_normal();
        for (int i = 0; i < 40; i++)
            step("R1 normal comb", "R7 normal regs", 2'b00, rnd64(), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    endtask

    task automatic t_f1_rule();
        // f1=1, f0=0: result shows which was packed
        step("R1 normal comb", "R8 f1 packed when unregistered", 2'b00, 64'h0,
             8'h80, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R8 q1 is f1", {7'd0, q1}, 8'd1);
        step("R1 normal comb", "R8 f0 used when registered", 2'b00, 64'h0,
             8'h80, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 q1 is f0", {7'd0, q1}, 8'd0);
        step("R1 normal comb", "R8 alt off packs f0", 2'b00, 64'h0,
             8'h40, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 q1 is f0 alt off", {7'd0, q1}, 8'd1);
    endtask

    task automatic t_extended();
        for (int i = 0; i < 40; i++)
            step("R2 extended comb", "R9 extended regs", 2'b01, rnd64(), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'b1, 1'($urandom));
    endtask

    task automatic t_arith();
        for (int i = 0; i < 60; i++)
            step("R3 arith comb", "R10 arith regs", 2'b10, rnd64(), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        step("R3 all-ones ripple", "R10 all-ones regs", 2'b10, {64{1'b1}}, 8'h00,
             1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 ripple outputs", {5'd0, carry_out, comb1, comb0}, 8'd7);
    endtask

    task automatic t_illegal();
        step("R3 preload comb", "R10 preload q=11", 2'b10, 64'h0, 8'h50, 1'b0,
             1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++)
            step("R4 illegal comb", "R4 illegal regs", 2'b11, rnd64(), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic t_hold_and_reset();
        step("R3 preload comb", "R10 preload q=11", 2'b10, 64'h0, 8'h50, 1'b0,
             1'b1, 1'b1, 1'b0);
        @(negedge clk);
        en = 1'b0; cfg_mode = 2'b11; data_in = 8'h00;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R6 hold with en low", {6'd0, q1, q0}, 8'd3);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 reset with en low", {6'd0, q1, q0}, 8'd0);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; cfg_mode = 2'b00; cfg_mask = 64'h0;
        cfg_pack0 = 1'b0; cfg_pack1 = 1'b0; cfg_pack1_alt = 1'b0;
        data_in = 8'h00; carry_in = 1'b0;
        repeat (2) @(posedge clk);
        t_reset();
        t_normal();
        t_f1_rule();
        t_extended();
        t_arith();
        t_illegal();
        t_hold_and_reset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule